// File: doc/BRIEF.md
# Performance-monitor user access gate

This block sits between an instruction decoder and a small bank of performance-monitor registers: two control registers (control 0 and control 2) and six event counters. Each cycle it may receive one move-to or move-from special-register request, tagged with its privilege. The block decides at once whether the request may proceed. A permitted read returns the register value through a user-visibility mask. A permitted write merges the writable bits into the stored value. A refused request returns zero, changes nothing, and reports an exception code.

Permission depends on a 2-bit counter-access-control field stored inside control register 0. A user request carries a user register number, which the block turns into the privileged number by adding 0x10. Privileged requests use privileged numbers and skip every check and mask.

Top module: `pmu_user_gate`

## Requirements
- R1: After reset, all eight registers read 0, so the access-control field (control 0 bits 19:18) is 2'b00.
- R2: A user read of a mapped register raises facility-unavailable (code 1) when the field is 2'b01. It is allowed (code 0) for 2'b00, 2'b10 and 2'b11, except as stated in R4.
- R3: A user write is allowed only when the field is 2'b10 or 2'b11. It raises facility-unavailable (code 1) at 2'b01 and hypervisor-emulation (code 2) at 2'b00.
- R4: When the field is 2'b11, any user read or write of counter 5 or counter 6 raises facility-unavailable (code 1).
- R5: A user register number plus 0x10 selects the privileged register. Privileged numbers: control 0 = 0x1B, control 2 = 0x11, counters 1..6 = 0x13..0x18. Counters are read and written in full by permitted user accesses.
- R6: A permitted user read of control 0 returns only bit 31 (freeze), bit 26 (alert enable) and bit 7 (alert occurred); every other bit reads 0.
- R7: A permitted user write to control 0 or control 2 stores (old AND NOT mask) OR (data AND mask).
- R8: The user mask of control 2 covers the per-counter freeze-in-user-state bits 0, 9, 18, 27, 36 and 45. Other bits read 0 to a user and are not changed by user writes.
- R9: Privileged requests never raise an exception, and they read and write all 64 bits.
- R10: A refused request leaves every register unchanged and returns 0 on the read data.
- R11: The exception code and read data are valid in the cycle of the request. A write becomes visible from the next cycle.
- R12: A request to an unmapped number raises no exception, returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_num | input | 10 | Register number |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Masked read data (0 when refused) |
| exc_code | output | 2 | 0 none, 1 facility-unavailable, 2 hypervisor-emulation |

## Verification
The decision and the bank update both take place in the cycle that control 0 itself is written. A user write to control 0 is judged on the access field it is about to merge into, and a privileged write that changes the field is followed at once by user requests that must see the new field. Random sequences make privileged control-0 writes dense enough that the field changes often between user requests. Every outcome is compared against a bench model of the bank. Directed sweeps go over all four field values for reads and writes of control 0, of counter 1 and of counters 5 and 6, then read the bank back in privileged mode to confirm that refused writes left it intact.

// File: rtl/pmu_user_gate.sv
module pmu_user_gate #(
  parameter int DW         = 64,
  parameter int NW         = 10,
  parameter int USER_OFS   = 16,
  parameter int CTL0_NUM   = 'h1B,
  parameter int CTL2_NUM   = 'h11,
  parameter int CTR_BASE   = 'h13,
  parameter int NCTR       = 6,
  parameter int CC_LSB     = 18,
  parameter int FC_BIT     = 31,
  parameter int AE_BIT     = 26,
  parameter int AO_BIT     = 7,
  parameter int FZP_LSB    = 0,
  parameter int FZP_STRIDE = 9,
  parameter int EXCL_LO    = 5,
  parameter int EXCL_HI    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_user,
  input  logic [NW-1:0] req_num,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    exc_code
);

  localparam logic [1:0] EXC_NONE = 2'd0;
  localparam logic [1:0] EXC_FU   = 2'd1;
  localparam logic [1:0] EXC_HEA  = 2'd2;

  function automatic logic [DW-1:0] ctl2_umask_f();
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NCTR; i++) m[FZP_LSB + i*FZP_STRIDE] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] CTL0_UMASK =
    (DW'(1) << FC_BIT) | (DW'(1) << AE_BIT) | (DW'(1) << AO_BIT);
  localparam logic [DW-1:0] CTL2_UMASK = ctl2_umask_f();

  logic [DW-1:0] ctl0_q, ctl2_q;
  logic [DW-1:0] ctr_q [NCTR];

  logic [NW-1:0]   eff_num;
  logic            hit_ctl0, hit_ctl2, mapped, excl, grant, we;
  logic [NCTR-1:0] ctr_hit, excl_hit;
  logic [1:0]      cc;
  logic [DW-1:0]   raw, umask, merged;

  assign eff_num  = req_user ? req_num + NW'(USER_OFS) : req_num;
  assign hit_ctl0 = eff_num == NW'(CTL0_NUM);
  assign hit_ctl2 = eff_num == NW'(CTL2_NUM);

  for (genvar i = 0; i < NCTR; i++) begin : g_dec
    assign ctr_hit[i]  = eff_num == NW'(CTR_BASE + i);
    assign excl_hit[i] = ctr_hit[i] && (i + 1 >= EXCL_LO) && (i + 1 <= EXCL_HI);
  end

  assign mapped = hit_ctl0 | hit_ctl2 | (|ctr_hit);
  assign cc     = ctl0_q[CC_LSB +: 2];
  assign excl   = (|excl_hit) && cc == 2'b11;

  always_comb begin
    exc_code = EXC_NONE;
    if (req_valid && req_user && mapped) begin
      if (excl)                 exc_code = EXC_FU;
      else if (req_write)       exc_code = cc[1] ? EXC_NONE : (cc[0] ? EXC_FU : EXC_HEA);
      else if (cc == 2'b01)     exc_code = EXC_FU;
    end
  end

  assign grant = req_valid && mapped && exc_code == EXC_NONE;
  assign we    = grant && req_write;

  always_comb begin
    raw = '0;
    if (hit_ctl0) raw = ctl0_q;
    if (hit_ctl2) raw = ctl2_q;
    for (int i = 0; i < NCTR; i++)
      if (ctr_hit[i]) raw = ctr_q[i];
  end

  assign umask   = !req_user ? '1 : hit_ctl0 ? CTL0_UMASK : hit_ctl2 ? CTL2_UMASK : '1;
  assign rd_data = (grant && !req_write) ? (raw & umask) : '0;
  assign merged  = (raw & ~umask) | (req_wdata & umask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0_q <= '0;
      ctl2_q <= '0;
      for (int i = 0; i < NCTR; i++) ctr_q[i] <= '0;
    end else if (we) begin
      if (hit_ctl0) ctl0_q <= merged;
      if (hit_ctl2) ctl2_q <= merged;
      for (int i = 0; i < NCTR; i++)
        if (ctr_hit[i]) ctr_q[i] <= merged;
    end
  end

endmodule

module pmu_user_gate_chk #(
  parameter int DW       = 64,
  parameter int NW       = 10,
  parameter int USER_OFS = 16,
  parameter int CTL0_NUM = 'h1B,
  parameter int CTR_BASE = 'h13,
  parameter int CC_LSB   = 18,
  parameter int FC_BIT   = 31,
  parameter int AE_BIT   = 26,
  parameter int AO_BIT   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_user,
  input logic [NW-1:0] req_num,
  input logic [DW-1:0] req_wdata,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    exc_code,
  input logic [DW-1:0] ctl0_q,
  input logic [DW-1:0] ctl2_q
);
  localparam logic [DW-1:0] M0 =
    (DW'(1) << FC_BIT) | (DW'(1) << AE_BIT) | (DW'(1) << AO_BIT);

  logic [1:0] cc;
  logic u0, u56;
  assign cc  = ctl0_q[CC_LSB +: 2];
  assign u0  = req_valid && req_user && (req_num + NW'(USER_OFS) == NW'(CTL0_NUM));
  assign u56 = req_valid && req_user &&
               ((req_num + NW'(USER_OFS) == NW'(CTR_BASE + 4)) ||
                (req_num + NW'(USER_OFS) == NW'(CTR_BASE + 5)));

  AST_RD_FU_CC01: assert property (@(posedge clk) disable iff (!rst_n)
    u0 && !req_write && cc == 2'b01 |-> exc_code == 2'd1); // R2
  AST_WR_HEA_CC00: assert property (@(posedge clk) disable iff (!rst_n)
    u0 && req_write && cc == 2'b00 |-> exc_code == 2'd2); // R3
  AST_EXCL_CTR56: assert property (@(posedge clk) disable iff (!rst_n)
    u56 && cc == 2'b11 |-> exc_code == 2'd1); // R4
  AST_PRIV_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_user |-> exc_code == 2'd0); // R9
  AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && exc_code != 2'd0 |=> $stable(ctl0_q) && $stable(ctl2_q)); // R10
  AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code != 2'd0 |-> rd_data == '0); // R10
  AST_CTL0_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    u0 && !req_write && exc_code == 2'd0 |-> (rd_data & ~M0) == '0); // R6
  AST_CTL0_WR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    u0 && req_write && exc_code == 2'd0 |=>
      ctl0_q == (($past(ctl0_q) & ~M0) | ($past(req_wdata) & M0))); // R7
endmodule

bind pmu_user_gate pmu_user_gate_chk #(
  .DW(DW), .NW(NW), .USER_OFS(USER_OFS), .CTL0_NUM(CTL0_NUM), .CTR_BASE(CTR_BASE),
  .CC_LSB(CC_LSB), .FC_BIT(FC_BIT), .AE_BIT(AE_BIT), .AO_BIT(AO_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_user(req_user), .req_num(req_num), .req_wdata(req_wdata),
  .rd_data(rd_data), .exc_code(exc_code), .ctl0_q(ctl0_q), .ctl2_q(ctl2_q)
);

// File: tb/pmu_user_gate_bench.sv
module pmu_user_gate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [9:0]  req_num = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rd_data;
  logic [1:0]  exc_code;

  int total = 0, bad = 0;
  logic [63:0] model [8];

  always #4 clk = ~clk;

  pmu_user_gate u_pmu_user_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_num(req_num), .req_wdata(req_wdata),
    .rd_data(rd_data), .exc_code(exc_code)
  );

  localparam logic [63:0] M0 = (64'd1 << 31) | (64'd1 << 26) | (64'd1 << 7);
  localparam logic [63:0] M2 = (64'd1 << 0) | (64'd1 << 9) | (64'd1 << 18) |
                               (64'd1 << 27) | (64'd1 << 36) | (64'd1 << 45);

  // index: 0 ctl0, 1 ctl2, 2..7 counters 1..6, -1 unmapped
  function automatic int idx_of(logic user, logic [9:0] n);
    logic [9:0] p = user ? n + 10'h10 : n;
    if (p == 10'h1B) return 0;
    if (p == 10'h11) return 1;
    if (p >= 10'h13 && p <= 10'h18) return int'(p - 10'h13) + 2;
    return -1;
  endfunction

  function automatic logic [63:0] mask_of(logic user, int idx);
    if (!user) return '1;
    if (idx == 0) return M0;
    if (idx == 1) return M2;
    return '1;
  endfunction

  function automatic logic [1:0] exp_exc(logic user, logic wr, int idx, logic [1:0] cc);
    if (!user || idx < 0) return 2'd0;
    if ((idx == 6 || idx == 7) && cc == 2'b11) return 2'd1;
    if (wr) return cc[1] ? 2'd0 : (cc[0] ? 2'd1 : 2'd2);
    return (cc == 2'b01) ? 2'd1 : 2'd0;
  endfunction

  function automatic string auto_tag(logic user, logic wr, int idx, logic [1:0] e, logic [1:0] cc);
    if (e != 0) return ((idx == 6 || idx == 7) && cc == 2'b11) ? "R4" : (wr ? "R3" : "R2");
    if (idx < 0) return "R12";
    if (!user) return "R9";
    if (idx == 0) return wr ? "R7" : "R6";
    if (idx == 1) return wr ? "R7" : "R8";
    return "R5";
  endfunction

  task automatic op(logic user, logic wr, logic [9:0] n, logic [63:0] d, string tag);
    int idx;
    logic [1:0] cc, e;
    logic [63:0] m, er;
    string t;
    @(negedge clk);
    req_valid = 1; req_user = user; req_write = wr; req_num = n; req_wdata = d;
    idx = idx_of(user, n);
    cc  = model[0][19:18];
    e   = exp_exc(user, wr, idx, cc);
    m   = mask_of(user, idx);
    er  = (!wr && e == 0 && idx >= 0) ? (model[idx] & m) : 64'd0;
    t   = (tag == "") ? auto_tag(user, wr, idx, e, cc) : tag;
    #1;
    total++;
    if (exc_code !== e) begin
      bad++;
      $display("FAIL %s exc num=%h user=%0b wr=%0b cc=%b got=%0d exp=%0d", t, n, user, wr, cc, exc_code, e);
    end
    total++;
    if (rd_data !== er) begin
      bad++;
      $display("FAIL %s rdata num=%h user=%0b got=%h exp=%h", t, n, user, rd_data, er);
    end
    if (wr && e == 0 && idx >= 0) model[idx] = (model[idx] & ~m) | (d & m);
  endtask

  function automatic logic [9:0] pick_num(int k);
    case (k)
      0: return 10'h01B; 1: return 10'h011; 2: return 10'h00B; 3: return 10'h001;
      4: return 10'h02B; 5: return 10'h000; 6: return 10'h3FF;
      default: return (k % 2 == 0) ? 10'h013 + 10'(k % 6) : 10'h003 + 10'(k % 6);
    endcase
  endfunction

  task automatic set_cc(logic [1:0] v);
    op(1'b0, 1'b1, 10'h1B, (model[0] & ~(64'h3 << 18)) | (64'(v) << 18), "R9");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    op(1'b0, 1'b0, 10'h1B, '0, "R1");
    op(1'b0, 1'b0, 10'h11, '0, "R1");
    for (int i = 0; i < 6; i++) op(1'b0, 1'b0, 10'h13 + 10'(i), '0, "R1");
    // R3 at cc 00, then R10: bank untouched after refusal
    op(1'b1, 1'b1, 10'h00B, '1, "R3");
    op(1'b0, 1'b0, 10'h1B, '0, "R10");
    for (int c = 0; c < 4; c++) begin
      set_cc(2'(c));
      // R11: new cc is seen the very next cycle
      op(1'b1, 1'b0, 10'h00B, '0, "R11");
      op(1'b1, 1'b1, 10'h00B, 64'hFFFF_FFFF_FFF3_FFFF, "");
      op(1'b1, 1'b1, 10'h001, 64'hAAAA_5555_FFFF_0000, "");
      op(1'b1, 1'b0, 10'h001, '0, "");
      op(1'b1, 1'b1, 10'h003, 64'h1234_5678_9ABC_DEF0 + 64'(c), "");
      op(1'b1, 1'b0, 10'h003, '0, "R5");
      op(1'b1, 1'b1, 10'h007, 64'hC0FFEE00 + 64'(c), "");
      op(1'b1, 1'b0, 10'h008, '0, "");
      op(1'b1, 1'b0, 10'h02B, '0, "R12");
      op(1'b0, 1'b0, 10'h17, '0, "R10");
      op(1'b0, 1'b0, 10'h1B, '0, "R10");
    end
    for (int i = 0; i < 3000; i++) begin
      int k = int'($urandom_range(0, 12));
      logic u = 1'($urandom);
      logic w = 1'($urandom);
      logic [63:0] d = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) set_cc(2'($urandom));
      else op(u, w, pick_num(k), d, "");
    end
    @(negedge clk);
    req_valid = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule